// File: doc/BRIEF.md
# Touch Panel Measurement Sequencer

This block runs an autonomous scan of a resistive touch panel. A single configuration write picks a scan list (X, Y, the two pressure channels Z1/Z2, or the auxiliary input), a sample count of six or ten, and a settling interval. The block then visits each channel of the list in turn. For each channel it presents a switch-select code to the panel drivers. For every sample it waits the settling interval and then asks the converter for one result through a request/done handshake. It keeps a trimmed mean of the samples: the smallest and largest are dropped and the rest are averaged. The mean goes into the next free result slot, starting at slot 0.

A status field and an active-low pen interrupt report progress. The interrupt is held low for the whole scan and driven high when the last result is stored. Normal pen sensing comes back only after a re-enable delay. Each result slot empties when it is read. A start write that arrives while a scan is running is ignored. A dedicated abort input stops any scan and empties every slot.

The converter handshake has no back-pressure on the block side. `conv_req` stays high until the converter returns `conv_done`, and the result on `conv_data` is taken in that same cycle. `conv_done` has no effect at any other time.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `status` reads 0000, `conv_req` and `sw_sel` are 0, `pen_en` is 1 and `pen_irq_n` is the inverse of `pen_touch`.
- R2: When a start is accepted on a clock edge, from the next cycle `status` reads 0001 (busy), `pen_irq_n` is 0, `pen_en` is 0 and `sw_sel` shows the first channel of the list.
- R3: `sw_sel` codes are 1 = X, 2 = Y, 3 = Z1, 4 = Z2 and 5 = auxiliary, with 0 meaning no channel. The `cfg_mode` lists are: 000 = X,Y,Z1,Z2; 001 = X,Y; 010 = X; 011 = Y; 100 = Z1,Z2; 110 = auxiliary. The channels are visited in that order.
- R4: `cfg_interval` codes 000 to 111 select a settling time of 0, 5, 10, 20, 50, 100, 200 or 500 µs. That is W = µs × CYC_PER_US clock cycles. `conv_req` rises exactly W cycles after the edge that begins a sample, or in the very next cycle when W is 0. A sample begins on the accepting edge, on the done edge of the previous sample of the same channel, or on the edge that stores the previous channel.
- R5: `conv_req` stays high until `conv_done` is sampled high. `conv_done` has no effect while `conv_req` is low.
- R6: Each channel takes 6 samples (`cfg_ten` = 0) or 10 samples (`cfg_ten` = 1). Its result is (sum − min − max) / (count − 2), truncated.
- R7: The k-th channel of the list is stored in slot k during the one cycle that follows its last `conv_done`. The next channel begins on the edge that ends that cycle.
- R8: After the last store, `status` reads 0010 (data available) and `pen_irq_n` is 1 for REEN_US × CYC_PER_US cycles. Then `pen_en` returns to 1 and `pen_irq_n` follows `pen_touch` again.
- R9: A start write while `status` is busy is ignored. The scan keeps its channel, timing and results, including when the write falls on the final store cycle.
- R10: With `five_wire` = 1, modes 000, 100 and 110 start nothing. Modes 101 and 111 never start a scan.
- R11: `rd_data` shows the content of slot `rd_slot`, or 0 if that slot is empty. A cycle with `rd_en` high empties the slot. Once every slot is empty and no scan is running, `status` returns to 0000.
- R12: `scan_abort` sends the block to idle on the next cycle, drops `conv_req` and empties all slots.
- R13: An accepted start empties all slots left from the previous scan, so a slot that the new list does not reach reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_abort | input | 1 | Stops any scan and empties all slots |
| five_wire | input | 1 | Panel type: 1 = five-wire, 0 = four-wire |
| cfg_wr | input | 1 | Start write strobe |
| cfg_mode | input | 3 | Scan list code |
| cfg_ten | input | 1 | Sample count: 0 = six, 1 = ten |
| cfg_interval | input | 3 | Settling interval code |
| pen_touch | input | 1 | Raw pen contact sense, high when touched |
| conv_req | output | 1 | Conversion request, held until done |
| conv_done | input | 1 | Conversion complete, data valid |
| conv_data | input | DW | Conversion result |
| sw_sel | output | 3 | Panel switch-select channel code |
| rd_en | input | 1 | Read strobe, empties the addressed slot |
| rd_slot | input | 2 | Slot address for reading |
| rd_data | output | DW | Slot content, 0 when empty |
| status | output | 4 | 0000 idle, 0001 busy, 0010 data available |
| pen_irq_n | output | 1 | Active-low pen interrupt / scan-done flag |
| pen_en | output | 1 | Pen sensing enabled |

## Verification
Two things can land in one cycle here: a start write and the converter's completion or the final store of the scan. The bench raises `cfg_wr` in the same cycle as the first `conv_done`, and again in the store cycle of the last channel. A behavioural model checks on every clock that the channel code, the request timing and the status carry on as if no write had come. After the re-enable delay no second scan may begin. The stored results are then compared with trimmed means that the bench computes independently.

// File: rtl/tscan_pkg.sv
`timescale 1ns/1ps
package tscan_pkg;

  localparam int NSLOT  = 4;
  localparam int SLOT_W = 2;

  localparam logic [2:0] SW_NONE = 3'd0;
  localparam logic [2:0] SW_X    = 3'd1;
  localparam logic [2:0] SW_Y    = 3'd2;
  localparam logic [2:0] SW_Z1   = 3'd3;
  localparam logic [2:0] SW_AUX  = 3'd5;

  localparam logic [3:0] STAT_IDLE  = 4'b0000;
  localparam logic [3:0] STAT_BUSY  = 4'b0001;
  localparam logic [3:0] STAT_AVAIL = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CONV, ST_STORE, ST_HOLD
  } phase_e;

  typedef struct packed {
    logic       ok;
    logic [2:0] first;
    logic [2:0] len;
  } scan_plan_t;

  // settling time in microseconds for each interval code
  function automatic int unsigned interval_us(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 5;
      3'd2:    return 10;
      3'd3:    return 20;
      3'd4:    return 50;
      3'd5:    return 100;
      3'd6:    return 200;
      default: return 500;
    endcase
  endfunction

  // channel list for a mode code; lists are consecutive channel codes
  function automatic scan_plan_t decode_mode(input logic [2:0] mode, input logic five_wire);
    scan_plan_t p;
    p = '0;
    case (mode)
      3'b000: begin p.first = SW_X;   p.len = 3'd4; p.ok = !five_wire; end
      3'b001: begin p.first = SW_X;   p.len = 3'd2; p.ok = 1'b1;       end
      3'b010: begin p.first = SW_X;   p.len = 3'd1; p.ok = 1'b1;       end
      3'b011: begin p.first = SW_Y;   p.len = 3'd1; p.ok = 1'b1;       end
      3'b100: begin p.first = SW_Z1;  p.len = 3'd2; p.ok = !five_wire; end
      3'b110: begin p.first = SW_AUX; p.len = 3'd1; p.ok = !five_wire; end
      default: p.ok = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tscan_timer.sv
`timescale 1ns/1ps
module tscan_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // high in the last cycle of a loaded window
  assign expire = (cnt == TW'(1));
endmodule

// File: rtl/tscan_avg.sv
`timescale 1ns/1ps
module tscan_avg #(
  parameter int DW        = 12,
  parameter int SHORT_CNT = 6,
  parameter int LONG_CNT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add,
  input  logic          first,
  input  logic          long_mode,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] result
);
  localparam int SUMW = DW + $clog2(LONG_CNT + 1);
  localparam int SSH  = $clog2(SHORT_CNT - 2);
  localparam int LSH  = $clog2(LONG_CNT - 2);

  logic [SUMW-1:0] sum, trimmed, scaled;
  logic [DW-1:0]   mn, mx;
  logic [SUMW-1:0] din_x;

  assign din_x = {{(SUMW-DW){1'b0}}, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      mn  <= '0;
      mx  <= '0;
    end else if (add) begin
      if (first) begin
        sum <= din_x;
        mn  <= din;
        mx  <= din;
      end else begin
        sum <= sum + din_x;
        if (din < mn) mn <= din;
        if (din > mx) mx <= din;
      end
    end
  end

  always_comb begin
    trimmed = sum - {{(SUMW-DW){1'b0}}, mn} - {{(SUMW-DW){1'b0}}, mx};
    scaled  = long_mode ? (trimmed >> LSH) : (trimmed >> SSH);
    result  = scaled[DW-1:0];
  end
endmodule

// File: rtl/touch_scan_seq.sv
`timescale 1ns/1ps
module touch_scan_seq
  import tscan_pkg::*;
#(
  parameter int DW         = 12,
  parameter int CYC_PER_US = 50,
  parameter int REEN_US    = 20,
  parameter int SHORT_CNT  = 6,
  parameter int LONG_CNT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_abort,
  input  logic              five_wire,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_ten,
  input  logic [2:0]        cfg_interval,
  input  logic              pen_touch,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  output logic [2:0]        sw_sel,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DW-1:0]     rd_data,
  output logic [3:0]        status,
  output logic              pen_irq_n,
  output logic              pen_en
);
  localparam int MAX_US = (REEN_US > 500) ? REEN_US : 500;
  localparam int TW     = $clog2(MAX_US * CYC_PER_US + 1);
  localparam int CW     = $clog2(LONG_CNT);
  localparam logic [TW-1:0] HOLD_CYC = TW'(REEN_US * CYC_PER_US);

  function automatic logic [TW-1:0] wait_cycles(input logic [2:0] code);
    return TW'(interval_us(code) * CYC_PER_US);
  endfunction

  phase_e            state;
  scan_plan_t        plan, cur;
  logic              ten_q;
  logic [TW-1:0]     wcyc_q, w_next, tmr_val;
  logic              tmr_load, tmr_exp;
  logic [CW-1:0]     samp;
  logic [SLOT_W-1:0] ch_idx;
  logic [DW-1:0]     slot_q [NSLOT];
  logic [NSLOT-1:0]  slot_vld;
  logic [DW-1:0]     avg;
  logic scanning, accept, last_samp, last_ch, sample_done, begin_now, finish;

  always_comb begin
    plan        = decode_mode(cfg_mode, five_wire);
    scanning    = (state == ST_WAIT) || (state == ST_CONV) || (state == ST_STORE);
    accept      = ((state == ST_IDLE) || (state == ST_HOLD)) && cfg_wr && plan.ok;
    last_samp   = (samp == (ten_q ? CW'(LONG_CNT - 1) : CW'(SHORT_CNT - 1)));
    last_ch     = ((3'(ch_idx) + 3'd1) == cur.len);
    sample_done = (state == ST_CONV) && conv_done;
    finish      = (state == ST_STORE) && last_ch;
    begin_now   = accept || (sample_done && !last_samp) || ((state == ST_STORE) && !last_ch);
    w_next      = accept ? wait_cycles(cfg_interval) : wcyc_q;
    tmr_load    = (begin_now && (w_next != '0)) || finish;
    tmr_val     = finish ? HOLD_CYC : w_next;
  end

  tscan_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expire(tmr_exp)
  );

  tscan_avg #(.DW(DW), .SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_avg (
    .clk(clk), .rst_n(rst_n), .add(sample_done), .first(samp == '0),
    .long_mode(ten_q), .din(conv_data), .result(avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur      <= '0;
      ten_q    <= 1'b0;
      wcyc_q   <= '0;
      samp     <= '0;
      ch_idx   <= '0;
      slot_vld <= '0;
    end else if (scan_abort) begin
      state    <= ST_IDLE;
      samp     <= '0;
      ch_idx   <= '0;
      slot_vld <= '0;
    end else begin
      if (rd_en) slot_vld[rd_slot] <= 1'b0;
      if (begin_now) state <= (w_next == '0) ? ST_CONV : ST_WAIT;
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            cur      <= plan;
            ten_q    <= cfg_ten;
            wcyc_q   <= wait_cycles(cfg_interval);
            samp     <= '0;
            ch_idx   <= '0;
            slot_vld <= '0;
          end else if ((state == ST_HOLD) && tmr_exp) begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: if (tmr_exp) state <= ST_CONV;
        ST_CONV: begin
          if (conv_done) begin
            if (last_samp) state <= ST_STORE;
            else           samp  <= samp + 1'b1;
          end
        end
        ST_STORE: begin
          slot_vld[ch_idx] <= 1'b1;
          samp             <= '0;
          if (last_ch) state  <= ST_HOLD;
          else         ch_idx <= ch_idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((state == ST_STORE) && !scan_abort) slot_q[ch_idx] <= avg;
  end

  always_comb begin
    rd_data  = slot_vld[rd_slot] ? slot_q[rd_slot] : '0;
    sw_sel   = scanning ? (cur.first + 3'(ch_idx)) : SW_NONE;
    conv_req = (state == ST_CONV);
    status   = scanning ? STAT_BUSY : ((|slot_vld) ? STAT_AVAIL : STAT_IDLE);
    pen_en   = (state == ST_IDLE);
    case (state)
      ST_IDLE: pen_irq_n = !pen_touch;
      ST_HOLD: pen_irq_n = 1'b1;
      default: pen_irq_n = 1'b0;
    endcase
  end
endmodule

// File: rtl/tscan_chk.sv
`timescale 1ns/1ps
module tscan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_abort,
  input logic       cfg_wr,
  input logic       conv_req,
  input logic       conv_done,
  input logic [2:0] sw_sel,
  input logic [3:0] status,
  input logic       pen_irq_n,
  input logic       pen_en
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done && !scan_abort |=> conv_req);

  // R2
  busy_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'b0001) |-> (!pen_irq_n && !pen_en));

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_abort |=> (status == 4'b0000) && !conv_req && pen_en);

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status) && (status[3:2] == 2'b00));

  // R3
  req_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (sw_sel != 3'd0) && (status == 4'b0001));

  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'b0001) && cfg_wr && !scan_abort |=> (status != 4'b0000));

  // R8
  reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pen_en) && !$past(scan_abort) |-> $past(pen_irq_n));
endmodule

bind touch_scan_seq tscan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scan_abort(scan_abort), .cfg_wr(cfg_wr),
  .conv_req(conv_req), .conv_done(conv_done), .sw_sel(sw_sel),
  .status(status), .pen_irq_n(pen_irq_n), .pen_en(pen_en)
);

// File: tb/touch_scan_seq_bench.sv
`timescale 1ns/1ps
module touch_scan_seq_bench;
  localparam int CPU = 2;
  localparam int REEN = 20;
  localparam int HOLD = REEN * CPU;
  localparam int LAT = 20;

  logic clk = 0, rst_n = 0, scan_abort = 0, five_wire = 0, cfg_wr = 0, cfg_ten = 0;
  logic [2:0] cfg_mode = 0, cfg_interval = 0;
  logic pen_touch = 0, conv_done = 0, rd_en = 0;
  logic [11:0] conv_data = 0;
  logic [1:0] rd_slot = 0;
  logic conv_req, pen_irq_n, pen_en;
  logic [2:0] sw_sel;
  logic [11:0] rd_data;
  logic [3:0] status;

  touch_scan_seq #(.DW(12), .CYC_PER_US(CPU), .REEN_US(REEN)) u_touch_scan_seq (
    .clk(clk), .rst_n(rst_n), .scan_abort(scan_abort), .five_wire(five_wire),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_ten(cfg_ten), .cfg_interval(cfg_interval),
    .pen_touch(pen_touch), .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data),
    .sw_sel(sw_sel), .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data),
    .status(status), .pen_irq_n(pen_irq_n), .pen_en(pen_en)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit chk_on = 0;
  bit exp_req = 0, exp_pen_en = 1;
  int exp_sw = 0, exp_status = 0, exp_irq = 2;
  int exp_slot [4];
  bit exp_vld [4];
  string cur = "R1";

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  // per-clock comparison with the behavioural model
  always @(negedge clk) begin
    if (chk_on) begin
      bit ei;
      ei = (exp_irq == 2) ? !pen_touch : exp_irq[0];
      tests++;
      if (conv_req !== exp_req || int'(sw_sel) != exp_sw || int'(status) != exp_status ||
          pen_irq_n !== ei || pen_en !== exp_pen_en) begin
        fails++;
        $display("FAIL %s t=%0t actual req=%b sw=%0d st=%0d irq=%b en=%b expected req=%b sw=%0d st=%0d irq=%b en=%b",
                 cur, $time, conv_req, sw_sel, status, pen_irq_n, pen_en,
                 exp_req, exp_sw, exp_status, ei, exp_pen_en);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int us_of(input int code);
    case (code)
      0: return 0;   1: return 5;   2: return 10;  3: return 20;
      4: return 50;  5: return 100; 6: return 200; default: return 500;
    endcase
  endfunction

  function automatic int sval(input int ch, input int s);
    if (s == 1) return 4095 - ch;
    if (s == 3) return ch;
    return ch * 500 + s * 13 + 7;
  endfunction

  function automatic int trim_avg(input int q[$]);
    int s[$];
    int sum;
    s = q;
    s.sort();
    void'(s.pop_front());
    void'(s.pop_back());
    sum = 0;
    foreach (s[i]) sum += s[i];
    return sum / s.size();
  endfunction

  function automatic void idle_status();
    exp_status = (exp_vld[0] || exp_vld[1] || exp_vld[2] || exp_vld[3]) ? 2 : 0;
  endfunction

  task automatic scan(input logic [2:0] mode, input bit ten, input logic [2:0] iv, input bit poke);
    int chs[$];
    int n, w;
    case (mode)
      3'b000: begin chs.push_back(1); chs.push_back(2); chs.push_back(3); chs.push_back(4); end
      3'b001: begin chs.push_back(1); chs.push_back(2); end
      3'b010: chs.push_back(1);
      3'b011: chs.push_back(2);
      3'b100: begin chs.push_back(3); chs.push_back(4); end
      default: chs.push_back(5);
    endcase
    n = ten ? 10 : 6;
    w = us_of(int'(iv)) * CPU;
    cfg_mode = mode; cfg_ten = ten; cfg_interval = iv; cfg_wr = 1;
    tick();
    cfg_wr = 0;
    cur = "R2/R13";
    for (int k = 0; k < 4; k++) exp_vld[k] = 0;
    exp_status = 1; exp_irq = 0; exp_pen_en = 0;
    for (int ci = 0; ci < chs.size(); ci++) begin
      int q[$];
      exp_sw = chs[ci];
      for (int s = 0; s < n; s++) begin
        cur = "R3/R4";
        if (w > 0) begin exp_req = 0; repeat (w) tick(); end
        exp_req = 1;
        cur = "R5";
        repeat (LAT) tick();
        q.push_back(sval(chs[ci], s));
        conv_done = 1; conv_data = 12'(sval(chs[ci], s));
        if (poke && ci == 0 && s == 0) begin cfg_wr = 1; cfg_mode = 3'b010; cur = "R9"; end
        tick();
        conv_done = 0; cfg_wr = 0;
      end
      exp_req = 0;
      cur = "R7";
      if (poke && ci == chs.size() - 1) begin cfg_wr = 1; cfg_mode = 3'b011; cur = "R9"; end
      tick();
      cfg_wr = 0;
      exp_slot[ci] = trim_avg(q);
      exp_vld[ci] = 1;
    end
    exp_sw = 0; exp_status = 2; exp_irq = 1; cur = "R8";
    repeat (HOLD) tick();
    exp_pen_en = 1; exp_irq = 2; cur = "R1/R9";
    tick();
    chk(status == 4'b0010 && pen_en, "R8", int'(status), 2);
  endtask

  task automatic read_slot(input int k, input string tag);
    int e;
    e = exp_vld[k] ? exp_slot[k] : 0;
    rd_en = 1; rd_slot = 2'(k);
    @(negedge clk);
    chk(int'(rd_data) == e, tag, int'(rd_data), e);
    tick();
    rd_en = 0;
    exp_vld[k] = 0;
    idle_status();
  endtask

  task automatic reject(input logic [2:0] mode, input bit fw);
    cur = "R10";
    five_wire = fw; cfg_mode = mode; cfg_wr = 1;
    tick();
    cfg_wr = 0;
    repeat (3) tick();
    @(negedge clk);
    chk(int'(status) == exp_status && !conv_req && pen_en, "R10", int'(status), exp_status);
    tick();
  endtask

  initial begin
    exp_vld = '{0, 0, 0, 0};
    exp_slot = '{0, 0, 0, 0};
    repeat (3) tick();
    rst_n = 1;
    chk_on = 1;
    @(negedge clk);
    chk(status == 4'b0000 && !conv_req && sw_sel == 3'd0 && pen_en, "R1", int'(status), 0);
    chk(rd_data == 12'd0, "R11", int'(rd_data), 0);
    tick();
    pen_touch = 1;
    tick();
    @(negedge clk);
    chk(pen_irq_n == 1'b0, "R1", int'(pen_irq_n), 0);
    tick();
    pen_touch = 0;
    tick();

    // full four-channel list with starts poked mid-scan and on the last store
    scan(3'b000, 0, 3'd1, 1);
    for (int k = 0; k < 4; k++) read_slot(k, "R6/R7/R11");
    @(negedge clk);
    chk(status == 4'b0000, "R11", int'(status), 0);
    tick();

    // zero interval, ten samples, then a new scan empties the old slots
    scan(3'b001, 1, 3'd0, 0);
    scan(3'b010, 0, 3'd7, 0);
    read_slot(0, "R6");
    read_slot(1, "R13");

    // five-wire rejections and one accepted five-wire scan
    reject(3'b000, 1);
    reject(3'b100, 1);
    reject(3'b110, 1);
    reject(3'b101, 1);
    scan(3'b011, 0, 3'd2, 0);
    five_wire = 0;
    reject(3'b111, 0);
    read_slot(0, "R3");

    scan(3'b100, 1, 3'd3, 0);
    read_slot(1, "R6");
    scan(3'b110, 0, 3'd0, 0);

    // abort with data waiting
    cur = "R12";
    scan_abort = 1;
    tick();
    scan_abort = 0;
    for (int k = 0; k < 4; k++) exp_vld[k] = 0;
    exp_status = 0;
    @(negedge clk);
    chk(status == 4'b0000, "R12", int'(status), 0);
    read_slot(0, "R12");

    // abort during a settling wait
    cfg_mode = 3'b000; cfg_ten = 0; cfg_interval = 3'd2; cfg_wr = 1;
    tick();
    cfg_wr = 0;
    exp_status = 1; exp_irq = 0; exp_pen_en = 0; exp_sw = 1; exp_req = 0; cur = "R2";
    repeat (5) tick();
    scan_abort = 1; cur = "R12";
    tick();
    scan_abort = 0;
    exp_status = 0; exp_irq = 2; exp_pen_en = 1; exp_sw = 0;
    repeat (30) tick();
    @(negedge clk);
    chk(!conv_req && status == 4'b0000, "R12", int'(conv_req), 0);

    chk_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule